// File: doc/BRIEF.md
# Latched Splittable Performance Counter Bank

This block holds four 32-bit physical event counters behind a small register port whose words are 64 bits wide. Each physical counter can run as one 32-bit counter or be split at run time into two independent 16-bit halves, which gives eight logical counters. Each counter increments on the cycles its event input is high, and only while the monitor is enabled.

A software write to a counter address does not change the running count. The value is parked in a per-counter latch. It moves into the counter only when the control register is written with its enable bit set, and this happens even if the monitor is already running. Wrapping counters raise flags in a status register. Reading that register returns the flags and clears them. Writing it sets the interrupt enable mask, and the interrupt output combines the flags with that mask.

Top module: `pcb_bank`

## Requirements
- R1: Address map (addr_i): 0..3 select logical counters 0..3, 4..7 select logical counters 4..7, 8 selects control and 9 selects status. Logical counters n and n+4 both belong to physical counter n. In split mode, n is the upper 16 bits of physical counter n and n+4 is the lower 16 bits, each read back zero-extended. In 32-bit mode both addresses access the whole counter.
- R2: A counter write only loads that counter's latch and marks it pending. While the write is pending, a read returns the latch value. Otherwise a read returns the live count.
- R3: A control write with bit 0 (enable) set copies every pending latch into its counter and clears the pending marks, even when the monitor is already enabled.
- R4: While enabled, a 32-bit counter adds one on each cycle that evt_i[n] is high. Clearing the enable bit freezes all counts, and pending latches keep their values.
- R5: Control bit 1+n selects split mode for physical counter n. In split mode the upper half counts evt_i[n] and the lower half counts evt_i[n+4], with no carry between the halves. In 32-bit mode evt_i[n+4] has no effect.
- R6: In split mode, a write to one half keeps the other half at its current read value (the latch value if pending, the live value otherwise).
- R7: When a 32-bit counter n or its upper half wraps from all ones to zero, status bit n is set. When a lower half n+4 wraps, status bit n+4 is set.
- R8: A status read returns the flags in bits 7:0 and clears them. A flag set in the same cycle as the read survives the read.
- R9: A status write loads the interrupt mask from data bits 7:0. irq_o is high when any flag has its mask bit set, so a mask of zero keeps irq_o low.
- R10: Register data sits in bits 63:32 of the bus word. Bits 31:0 are ignored on writes and read as zero. Unmapped addresses read as zero and ignore writes.
- R11: After reset, all counters, latches, control, mask and flags are zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives the status clear) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 64 | Write data, upper 32 bits used |
| rdata_o | output | 64 | Combinational read data, upper 32 bits |
| evt_i | input | 8 | Event inputs, one per logical counter |
| irq_o | output | 1 | Masked overflow interrupt |

## Verification
The case of interest is a status read that falls in the same cycle as a lower-half wrap. The bench preloads half 5 with all ones and commits it. It then holds the status read strobe and evt_i[5] together for one cycle. The read data in that cycle must show no flags, and a second status read must return bit 5, which shows that the new flag won over the clear. A second pairing checks commit against counting: a counter is written and then pulsed while its write is pending, and the read value must stay at the latch until a control write with enable set commits it.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  localparam int NUM_PHYS       = 4;
  localparam int DATA_W         = 32;
  localparam int ADDR_W         = 4;
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_SPLIT_LSB = 1;
endpackage

// File: rtl/pcb_counter.sv
`timescale 1ns/1ps
module pcb_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             split_i,
  input  logic             evt_hi_i,
  input  logic             evt_lo_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             commit_i,
  output logic [CNT_W-1:0] rd_o,
  output logic             pending_o,
  output logic             ovf_hi_o,
  output logic             ovf_lo_o
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, latch_q;
  logic             pend_q;

  always_comb begin
    cnt_d    = cnt_q;
    ovf_hi_o = 1'b0;
    ovf_lo_o = 1'b0;
    if (commit_i && pend_q) begin
      cnt_d = latch_q;  // commit overrides counting in that cycle
    end else if (cnt_en_i) begin
      if (split_i) begin
        if (evt_hi_i) begin
          cnt_d[CNT_W-1:HALF_W] = cnt_q[CNT_W-1:HALF_W] + HALF_W'(1);
          ovf_hi_o              = &cnt_q[CNT_W-1:HALF_W];
        end
        if (evt_lo_i) begin
          cnt_d[HALF_W-1:0] = cnt_q[HALF_W-1:0] + HALF_W'(1);
          ovf_lo_o          = &cnt_q[HALF_W-1:0];
        end
      end else if (evt_hi_i) begin
        cnt_d    = cnt_q + CNT_W'(1);
        ovf_hi_o = &cnt_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_i) begin
        latch_q <= wr_data_i;
        pend_q  <= 1'b1;
      end else if (commit_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign rd_o      = pend_q ? latch_q : cnt_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/pcb_status.sv
`timescale 1ns/1ps
module pcb_status #(
  parameter int NUM_LOG = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LOG-1:0] set_i,
  input  logic               clr_i,
  input  logic               mask_wr_i,
  input  logic [NUM_LOG-1:0] mask_i,
  output logic [NUM_LOG-1:0] flags_o,
  output logic [NUM_LOG-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_LOG-1:0] flags_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= (clr_i ? '0 : flags_q) | set_i;  // new flags win over clear
      if (mask_wr_i) mask_q <= mask_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & mask_q);
endmodule

// File: rtl/pcb_bank.sv
`timescale 1ns/1ps
module pcb_bank
  import pcb_pkg::*;
#(
  parameter int NUM_PHYS = pcb_pkg::NUM_PHYS,
  parameter int DATA_W   = pcb_pkg::DATA_W,
  parameter int ADDR_W   = pcb_pkg::ADDR_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*DATA_W-1:0]   wdata_i,
  output logic [2*DATA_W-1:0]   rdata_o,
  input  logic [2*NUM_PHYS-1:0] evt_i,
  output logic                  irq_o
);
  localparam int NUM_LOG = 2 * NUM_PHYS;
  localparam int HALF_W  = DATA_W / 2;
  localparam int PIDX_W  = $clog2(NUM_PHYS);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_LOG);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(NUM_LOG + 1);

  logic [DATA_W-1:0]                 wdata, wr_val, sel_rd, rd_word;
  logic                              unused_low;
  logic                              en_q;
  logic [NUM_PHYS-1:0]               split_q;
  logic [NUM_PHYS-1:0][DATA_W-1:0]   cnt_rd;
  logic [NUM_PHYS-1:0]               pending;
  logic [NUM_LOG-1:0]                ovf_set, flags, mask;
  logic [PIDX_W-1:0]                 pidx;
  logic                              is_cnt, upper_sel, cnt_wr, ctrl_wr, commit;

  assign wdata      = wdata_i[2*DATA_W-1:DATA_W];
  assign unused_low = ^wdata_i[DATA_W-1:0];
  assign is_cnt     = addr_i < ADDR_W'(NUM_LOG);
  assign pidx       = addr_i[PIDX_W-1:0];
  assign upper_sel  = !addr_i[PIDX_W];
  assign cnt_wr     = wr_en_i && is_cnt;
  assign ctrl_wr    = wr_en_i && (addr_i == ADDR_CTRL);
  assign commit     = ctrl_wr && wdata[CTRL_EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      split_q <= '0;
    end else if (ctrl_wr) begin
      en_q    <= wdata[CTRL_EN_BIT];
      split_q <= wdata[CTRL_SPLIT_LSB +: NUM_PHYS];
    end
  end

  // merge a half write with the other half's visible value
  always_comb begin
    sel_rd = cnt_rd[pidx];
    wr_val = wdata;
    if (split_q[pidx])
      wr_val = upper_sel ? {wdata[HALF_W-1:0], sel_rd[HALF_W-1:0]}
                         : {sel_rd[DATA_W-1:HALF_W], wdata[HALF_W-1:0]};
  end

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_ctr
    pcb_counter #(.CNT_W(DATA_W)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_en_i  (en_q),
      .split_i   (split_q[p]),
      .evt_hi_i  (evt_i[p]),
      .evt_lo_i  (evt_i[p+NUM_PHYS]),
      .wr_i      (cnt_wr && (pidx == PIDX_W'(p))),
      .wr_data_i (wr_val),
      .commit_i  (commit),
      .rd_o      (cnt_rd[p]),
      .pending_o (pending[p]),
      .ovf_hi_o  (ovf_set[p]),
      .ovf_lo_o  (ovf_set[p+NUM_PHYS])
    );
  end

  pcb_status #(.NUM_LOG(NUM_LOG)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ovf_set),
    .clr_i     (rd_en_i && (addr_i == ADDR_STAT)),
    .mask_wr_i (wr_en_i && (addr_i == ADDR_STAT)),
    .mask_i    (wdata[NUM_LOG-1:0]),
    .flags_o   (flags),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_word = '0;
    if (is_cnt) begin
      if (split_q[pidx])
        rd_word = upper_sel ? {{HALF_W{1'b0}}, sel_rd[DATA_W-1:HALF_W]}
                            : {{HALF_W{1'b0}}, sel_rd[HALF_W-1:0]};
      else
        rd_word = sel_rd;
    end else if (addr_i == ADDR_CTRL) begin
      rd_word = DATA_W'({split_q, en_q});
    end else if (addr_i == ADDR_STAT) begin
      rd_word = DATA_W'(flags);
    end
  end

  assign rdata_o = {rd_word, {DATA_W{1'b0}}};
endmodule

// File: rtl/pcb_bank_chk.sv
`timescale 1ns/1ps
module pcb_bank_chk #(
  parameter int NUM_PHYS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              wr_en_i,
  input logic                              rd_en_i,
  input logic [ADDR_W-1:0]                 addr_i,
  input logic [2*DATA_W-1:0]               wdata_i,
  input logic                              en_q,
  input logic [NUM_PHYS-1:0][DATA_W-1:0]   cnt_rd,
  input logic [NUM_PHYS-1:0]               pending,
  input logic [2*NUM_PHYS-1:0]             ovf_set,
  input logic [2*NUM_PHYS-1:0]             flags,
  input logic                              irq_o
);
  localparam int NUM_LOG = 2 * NUM_PHYS;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_LOG);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(NUM_LOG + 1);

  p_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i < ADDR_W'(NUM_LOG)) |=> (pending != '0));

  p_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CTRL && wdata_i[DATA_W]) |=> (pending == '0));

  p_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr_en_i) |=> $stable(cnt_rd));

  p_flag_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_set != '0) |=> ((flags & $past(ovf_set)) == $past(ovf_set)));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_STAT && ovf_set == '0) |=> (flags == '0));

  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(ovf_set) != '0 || $past(wr_en_i && addr_i == ADDR_STAT)));
endmodule

bind pcb_bank pcb_bank_chk #(
  .NUM_PHYS(NUM_PHYS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .en_q    (en_q),
  .cnt_rd  (cnt_rd),
  .pending (pending),
  .ovf_set (ovf_set),
  .flags   (flags),
  .irq_o   (irq_o)
);

// File: tb/tb_pcb_bank.sv
`timescale 1ns/1ps
module tb_pcb_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [7:0]  evt = '0;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  localparam logic [3:0] A_CTRL = 4'd8;
  localparam logic [3:0] A_STAT = 4'd9;

  always #2.5 clk = ~clk;

  pcb_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  // {is_write, addr, data, expected}
  localparam int NV = 20;
  localparam logic [68:0] TBL [NV] = '{
    {1'b0, A_CTRL, 32'h0,        32'h0},        // R11 control zero
    {1'b0, A_STAT, 32'h0,        32'h0},        // R11 flags zero
    {1'b0, 4'd5,   32'h0,        32'h0},        // R11 counter zero
    {1'b1, 4'd0,   32'h11112222, 32'h0},        // R2 write goes to latch
    {1'b0, 4'd0,   32'h0,        32'h11112222}, // R2 pending read shows latch
    {1'b1, A_CTRL, 32'h00000009, 32'h0},        // R3 enable + split p2, commit
    {1'b0, A_CTRL, 32'h0,        32'h00000009}, // R1 control readback
    {1'b0, 4'd0,   32'h0,        32'h11112222}, // R1 32-bit read
    {1'b1, 4'd2,   32'h0000BEEF, 32'h0},        // R6 upper half write
    {1'b1, 4'd6,   32'h00001234, 32'h0},        // R6 lower half write keeps upper
    {1'b0, 4'd2,   32'h0,        32'h0000BEEF}, // R1 upper half read
    {1'b0, 4'd6,   32'h0,        32'h00001234}, // R1 lower half read
    {1'b1, A_CTRL, 32'h00000009, 32'h0},        // R3 commit while enabled
    {1'b0, 4'd6,   32'h0,        32'h00001234}, // R3 committed value
    {1'b1, A_CTRL, 32'h00000001, 32'h0},        // R5 back to 32-bit
    {1'b0, 4'd2,   32'h0,        32'hBEEF1234}, // R1 joined halves
    {1'b0, 4'hF,   32'h0,        32'h0},        // R10 unmapped reads zero
    {1'b1, 4'hB,   32'hFFFFFFFF, 32'h0},        // R10 unmapped write ignored
    {1'b0, A_CTRL, 32'h0,        32'h00000001}, // R10 control untouched
    {1'b0, 4'd6,   32'h0,        32'hBEEF1234}  // R1 alias in 32-bit mode
  };

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = {d, 32'hA5C3_0FF0};  // R10 low half is junk
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 chk(rdata, {exp, 32'h0}, tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e, input int cycles);
    @(negedge clk);
    evt = e;
    repeat (cycles) @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #100000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({63'h0, irq}, 64'h0, "R11 irq low in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][68]) bus_wr(TBL[i][67:64], TBL[i][63:32]);
      else            bus_rd(TBL[i][67:64], TBL[i][31:0], $sformatf("table step %0d", i));
    end

    // R2/R3: pending value hides counting until a commit while enabled
    bus_wr(4'd1, 32'h00000100);
    pulse(8'h02, 1);
    bus_rd(4'd1, 32'h00000100, "R2 latch hides live count");
    bus_wr(A_CTRL, 32'h1);
    bus_rd(4'd1, 32'h00000100, "R3 commit while enabled");
    pulse(8'h02, 2);
    bus_rd(4'd1, 32'h00000102, "R4 counts events");

    // R4: disabled counters freeze, latch kept
    bus_wr(A_CTRL, 32'h0);
    pulse(8'h02, 3);
    bus_rd(4'd1, 32'h00000102, "R4 frozen while disabled");
    bus_wr(4'd1, 32'h00000500);
    bus_rd(4'd1, 32'h00000500, "R4 latch kept while disabled");
    bus_wr(A_CTRL, 32'h1);

    // R7/R8/R9: 32-bit wrap
    bus_wr(A_STAT, 32'h000000FF);
    bus_wr(4'd3, 32'hFFFFFFFD);
    bus_wr(A_CTRL, 32'h1);
    pulse(8'h08, 3);
    chk({63'h0, irq}, 64'h1, "R9 irq on masked flag");
    bus_rd(4'd3, 32'h0, "R7 32-bit wrap to zero");
    bus_rd(A_STAT, 32'h08, "R8 status read returns flag");
    chk({63'h0, irq}, 64'h0, "R8 read cleared flag");

    // R5/R6/R7: split halves independent
    bus_wr(A_CTRL, 32'h5);
    bus_wr(4'd1, 32'h0000FFFF);
    bus_wr(4'd5, 32'h00000007);
    bus_wr(A_CTRL, 32'h5);
    pulse(8'h22, 1);
    bus_rd(4'd1, 32'h0, "R5 upper half wrap");
    bus_rd(4'd5, 32'h8, "R5 lower half no carry");
    bus_rd(A_STAT, 32'h02, "R7 upper half flag");
    pulse(8'h10, 2);
    bus_rd(4'd0, 32'h11112222, "R5 lower event ignored in 32-bit mode");

    // R8: overflow in the same cycle as a status read survives
    bus_wr(4'd5, 32'h0000FFFF);
    bus_wr(A_CTRL, 32'h5);
    @(negedge clk);
    rd_en = 1'b1; addr = A_STAT; evt = 8'h20;
    #1 chk(rdata, 64'h0, "R8 read before new flag");
    @(negedge clk);
    rd_en = 1'b0; evt = '0;
    bus_rd(A_STAT, 32'h20, "R8 same-cycle flag survives");

    // R9: zero mask keeps irq low
    bus_wr(A_STAT, 32'h0);
    bus_wr(4'd5, 32'h0000FFFF);
    bus_wr(A_CTRL, 32'h5);
    pulse(8'h20, 1);
    chk({63'h0, irq}, 64'h0, "R9 zero mask blocks irq");
    bus_rd(A_STAT, 32'h20, "R9 flag still recorded");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule